// File: doc/BRIEF.md
# DC-Only Inverse Transform Adder

This block reconstructs a transform block whose only nonzero coefficient is the DC term. A command carries a signed DC coefficient and a two-bit shape code selecting one of four block shapes (4 or 8 pixels wide, 4 or 8 rows tall). The block turns the coefficient into a single signed offset in two rounding integer stages. The first stage depends only on the block width and the second only on the block height. The offset is then added to every prediction pixel of the block, and each sum is clamped to the unsigned pixel range.

After a command is taken, prediction rows enter one per handshake, top row first. Each accepted row leaves one cycle later as a reconstructed row on an output handshake, and the final row of the block is flagged. The output stage holds its row for as long as the consumer stalls, and it can accept a new input row in the same cycle that the held row is taken.

Top module: `dcadd_blk`

## Requirements
- R1: The shape code `cmd_size` uses bit 0 = 1 for 8 pixels wide (0 for 4) and bit 1 = 1 for 8 rows tall (0 for 4). A block emits exactly 4 or 8 rows, and `out_last` is high only on the final one.
- R2: The first scaling stage depends on width. For 8-wide blocks s = (3*dc + 1) >>> 1. For 4-wide blocks s = (17*dc + 4) >>> 3. Shifts are arithmetic on signed values.
- R3: The second scaling stage depends on height. For 8-tall blocks off = (12*s + 64) >>> 7, which equals (3*s + 16) >>> 5. For 4-tall blocks off = (17*s + 64) >>> 7.
- R4: Each output pixel equals the prediction pixel plus the offset, saturated to 0..255.
- R5: In 4-wide blocks only lanes 0..3 carry pixels. Output lanes 4..7 are zero, and input lanes 4..7 have no effect. Lane k occupies bits [8k+7:8k].
- R6: `cmd_ready` is high exactly when no block is in progress. While it is high, `in_ready` is low, so prediction rows are not taken.
- R7: While `out_valid` is high and `out_ready` is low, `out_row` and `out_last` stay unchanged, and no row is lost or duplicated.
- R8: After reset `out_valid` and `in_ready` are low and `cmd_ready` is high.
- R9: Rows leave in the order they were accepted, top to bottom. An input row is taken only when the output register is empty or is being emptied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_dc | input | DC_W | Signed DC coefficient |
| cmd_size | input | 2 | Shape code: bit 0 width 8, bit 1 height 8 |
| in_valid | input | 1 | Prediction row offered |
| in_ready | output | 1 | Prediction row can be taken |
| in_row | input | LANES*PIX_W | Prediction row, lane 0 in the low bits |
| out_valid | output | 1 | Reconstructed row available |
| out_ready | input | 1 | Consumer takes the row |
| out_row | output | LANES*PIX_W | Reconstructed row |
| out_last | output | 1 | Final row of the block |

## Verification
A vector table runs all four shapes with a zero coefficient, small positive and negative coefficients, and coefficients at both ends of the 16-bit range. The zero coefficient shows that the rows pass through unchanged. The small coefficients tell the width stage apart from the height stage and expose rounding of negative values. The extreme coefficients drive every lane into the upper or the lower clamp. Pixel ramps that cross 255 show saturation of some lanes while others are still in range. Some vectors stall the output every third cycle, which shows that rows are held and kept in order. Directed cases compare two hand-computed offsets, drive nonzero upper lanes into 4-wide blocks, and offer rows while the block is idle.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;
   // shape code: bit 1 selects 8 rows, bit 0 selects 8 pixels per row
   typedef struct packed {
      logic tall;
      logic wide;
   } blk_shape_t;
endpackage

// File: rtl/dcadd_scale.sv
module dcadd_scale #(
   parameter int DC_W  = 16,
   parameter int PIX_W = 8
) (
   input  logic signed [DC_W-1:0]   dc,
   input  logic                     wide,
   input  logic                     tall,
   output logic signed [PIX_W+1:0]  offset
);
   localparam int SC_W    = DC_W + 12;
   localparam int OFF_W   = PIX_W + 2;
   localparam int OFF_MAX = (2 ** PIX_W) - 1;
   localparam int OFF_MIN = -(2 ** PIX_W);

   logic signed [SC_W-1:0] dcx;
   logic signed [SC_W-1:0] s1_wide, s1_narrow, s1;
   logic signed [SC_W-1:0] s2_tall, s2_short, s2;

   assign dcx = SC_W'(dc);

   // width stage
   assign s1_wide   = (dcx + (dcx <<< 1) + SC_W'(1)) >>> 1;
   assign s1_narrow = (dcx + (dcx <<< 4) + SC_W'(4)) >>> 3;
   assign s1        = wide ? s1_wide : s1_narrow;

   // height stage
   assign s2_tall   = ((s1 <<< 3) + (s1 <<< 2) + SC_W'(64)) >>> 7;
   assign s2_short  = ((s1 <<< 4) + s1 + SC_W'(64)) >>> 7;
   assign s2        = tall ? s2_tall : s2_short;

   // any magnitude beyond one pixel range saturates every lane anyway
   always_comb begin
      if (s2 > SC_W'(OFF_MAX))      offset = OFF_W'(OFF_MAX);
      else if (s2 < SC_W'(OFF_MIN)) offset = OFF_W'(OFF_MIN);
      else                          offset = s2[OFF_W-1:0];
   end
endmodule

// File: rtl/dcadd_lane.sv
module dcadd_lane #(
   parameter int PIX_W = 8
) (
   input  logic                    en,
   input  logic [PIX_W-1:0]        pix,
   input  logic signed [PIX_W+1:0] offset,
   output logic [PIX_W-1:0]        res
);
   localparam int SUM_W = PIX_W + 3;
   localparam int PMAX  = (2 ** PIX_W) - 1;

   logic signed [SUM_W-1:0] sum;

   assign sum = $signed({3'b000, pix}) + {offset[PIX_W+1], offset};

   always_comb begin
      if (!en)                          res = '0;
      else if (sum < 0)                 res = '0;
      else if (sum > SUM_W'(PMAX))      res = '1;
      else                              res = sum[PIX_W-1:0];
   end
endmodule

// File: rtl/dcadd_rowctl.sv
module dcadd_rowctl
   import dcadd_pkg::*;
#(
   parameter int MAX_ROWS = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_valid,
   input  blk_shape_t cmd_shape,
   input  logic       in_valid,
   input  logic       out_ready,
   output logic       cmd_ready,
   output logic       cmd_fire,
   output logic       in_ready,
   output logic       row_fire,
   output logic       out_valid,
   output logic       out_last,
   output blk_shape_t shape_q
);
   localparam int CNT_W = $clog2(MAX_ROWS);
   localparam logic [CNT_W-1:0] LAST_TALL  = CNT_W'(MAX_ROWS - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(MAX_ROWS / 2 - 1);

   logic             busy;
   logic [CNT_W-1:0] row_cnt;
   logic             at_last;

   assign cmd_ready = !busy;
   assign cmd_fire  = cmd_valid && !busy;
   assign in_ready  = busy && (!out_valid || out_ready);
   assign row_fire  = in_valid && in_ready;
   assign at_last   = (row_cnt == (shape_q.tall ? LAST_TALL : LAST_SHORT));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         row_cnt <= '0;
         shape_q <= '0;
      end else if (cmd_fire) begin
         busy    <= 1'b1;
         row_cnt <= '0;
         shape_q <= cmd_shape;
      end else if (row_fire) begin
         row_cnt <= row_cnt + 1'b1;
         if (at_last) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else if (row_fire) begin
         out_valid <= 1'b1;
         out_last  <= at_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end
   end
endmodule

// File: rtl/dcadd_blk.sv
module dcadd_blk
   import dcadd_pkg::*;
#(
   parameter int DC_W     = 16,
   parameter int PIX_W    = 8,
   parameter int LANES    = 8,
   parameter int MAX_ROWS = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [DC_W-1:0]        cmd_dc,
   input  logic [1:0]             cmd_size,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [LANES*PIX_W-1:0] in_row,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [LANES*PIX_W-1:0] out_row,
   output logic                   out_last
);
   localparam int HALF  = LANES / 2;
   localparam int OFF_W = PIX_W + 2;

   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("LANES must be even and at least 2");
      end
      if (MAX_ROWS < 2 || (MAX_ROWS % 2) != 0) begin : g_bad_rows
         $error("MAX_ROWS must be even and at least 2");
      end
      if (PIX_W < 2 || DC_W < 2) begin : g_bad_width
         $error("PIX_W and DC_W must be at least 2");
      end
   endgenerate

   blk_shape_t              shape_q;
   logic                    cmd_fire, row_fire;
   logic                    wide_q;
   logic signed [OFF_W-1:0] off_next, off_q;
   logic [LANES*PIX_W-1:0]  row_next;

   assign wide_q = shape_q.wide;

   dcadd_rowctl #(.MAX_ROWS(MAX_ROWS)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_shape (blk_shape_t'(cmd_size)),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .cmd_ready (cmd_ready),
      .cmd_fire  (cmd_fire),
      .in_ready  (in_ready),
      .row_fire  (row_fire),
      .out_valid (out_valid),
      .out_last  (out_last),
      .shape_q   (shape_q)
   );

   dcadd_scale #(.DC_W(DC_W), .PIX_W(PIX_W)) u_scale (
      .dc     ($signed(cmd_dc)),
      .wide   (cmd_size[0]),
      .tall   (cmd_size[1]),
      .offset (off_next)
   );

   always_ff @(posedge clk) begin
      if (rst)           off_q <= '0;
      else if (cmd_fire) off_q <= off_next;
   end

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic lane_en;
         if (g < HALF) begin : g_low
            assign lane_en = 1'b1;
         end else begin : g_high
            assign lane_en = wide_q;
         end
         dcadd_lane #(.PIX_W(PIX_W)) u_lane (
            .en     (lane_en),
            .pix    (in_row[g*PIX_W +: PIX_W]),
            .offset (off_q),
            .res    (row_next[g*PIX_W +: PIX_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           out_row <= '0;
      else if (row_fire) out_row <= row_next;
   end
endmodule

// File: rtl/dcadd_blk_chk.sv
module dcadd_blk_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst,
   input logic         cmd_ready,
   input logic         in_ready,
   input logic         out_valid,
   input logic         out_ready,
   input logic [W-1:0] out_row,
   input logic         out_last
);
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));

   p_in_gate_r9: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> (!out_valid || out_ready));

   p_idle_r6: assert property (@(posedge clk) disable iff (rst)
      cmd_ready |-> !in_ready);

   p_last_once_r1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_last) |=> !(out_valid && out_last));

   p_reset_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && !in_ready && cmd_ready));
endmodule

bind dcadd_blk dcadd_blk_chk #(.W(LANES*PIX_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_ready (cmd_ready),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_row   (out_row),
   .out_last  (out_last)
);

// File: tb/dcadd_blk_bench.sv
module dcadd_blk_bench;
   localparam int NV = 10;
   // size, dc, pixel base, stall
   localparam int VEC [NV][4] = '{
      '{0, 0, 77, 0},
      '{1, 100, 10, 0},
      '{2, -100, 200, 1},
      '{3, 500, 3, 1},
      '{0, 32767, 0, 0},
      '{3, -32768, 250, 0},
      '{1, -1, 128, 1},
      '{2, 37, 240, 0},
      '{3, -13, 5, 1},
      '{0, -300, 60, 1}
   };

   logic        clk = 0;
   logic        rst = 1;
   logic        cmd_valid = 0;
   logic        cmd_ready;
   logic [15:0] cmd_dc = '0;
   logic [1:0]  cmd_size = '0;
   logic        in_valid = 0;
   logic        in_ready;
   logic [63:0] in_row = '0;
   logic        out_valid;
   logic        out_ready = 0;
   logic [63:0] out_row;
   logic        out_last;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dcadd_blk u_dcadd_blk (
      .clk(clk), .rst(rst),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dc(cmd_dc), .cmd_size(cmd_size),
      .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_last(out_last)
   );

   function automatic int model_off(int sz, int dc);
      int s;
      s = (sz & 1) ? ((3 * dc + 1) >>> 1) : ((17 * dc + 4) >>> 3);
      return (sz & 2) ? ((12 * s + 64) >>> 7) : ((17 * s + 64) >>> 7);
   endfunction

   function automatic logic [7:0] pix(int base, int r, int l);
      return 8'((base + 37 * r + 23 * l) & 255);
   endfunction

   function automatic logic [63:0] in_of(int base, int r);
      logic [63:0] v;
      for (int l = 0; l < 8; l++) v[l*8 +: 8] = pix(base, r, l);
      return v;
   endfunction

   function automatic logic [63:0] exp_of(int sz, int off, int base, int r);
      logic [63:0] v;
      int t;
      for (int l = 0; l < 8; l++) begin
         t = int'(pix(base, r, l)) + off;
         if (t < 0) t = 0;
         if (t > 255) t = 255;
         v[l*8 +: 8] = ((sz & 1) == 0 && l >= 4) ? 8'd0 : 8'(t);
      end
      return v;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_block(int sz, int dc, int base, int stall, string req);
      int nrows, sent, got, cyc, off;
      logic held;
      logic [63:0] held_row;
      nrows = (sz & 2) ? 8 : 4;
      off = model_off(sz, dc);
      sent = 0; got = 0; cyc = 0; held = 0; held_row = '0;
      @(negedge clk);
      check("R6 cmd_ready idle", 64'(cmd_ready), 64'd1);
      cmd_valid = 1; cmd_size = 2'(sz); cmd_dc = 16'(dc);
      @(negedge clk);
      cmd_valid = 0;
      check("R6 cmd_ready low while busy", 64'(cmd_ready), 64'd0);
      while (got < nrows) begin
         logic do_in, do_out;
         if (cyc > 0) @(negedge clk);
         if (held) check("R7 row held under stall", out_row, held_row);
         out_ready = (stall == 0) || ((cyc % 3) != 1);
         in_valid = (sent < nrows);
         in_row = in_of(base, sent);
         cyc++;
         #1;
         do_in = in_valid && in_ready;
         do_out = out_valid && out_ready;
         held = out_valid && !out_ready;
         held_row = out_row;
         if (do_out) begin
            check($sformatf("%s R4 R9 row %0d", req, got), out_row, exp_of(sz, off, base, got));
            check("R1 last flag", 64'(out_last), 64'(got == nrows - 1));
            got++;
         end
         if (do_in) sent++;
      end
      @(negedge clk);
      in_valid = 0; out_ready = 0;
      #1;
      check("R1 no extra rows", 64'(out_valid), 64'd0);
      check("R6 idle after block", 64'(cmd_ready), 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 out_valid after reset", 64'(out_valid), 64'd0);
      check("R8 in_ready after reset", 64'(in_ready), 64'd0);
      check("R8 cmd_ready after reset", 64'(cmd_ready), 64'd1);
      rst = 0;
      // R6: rows offered while idle are not taken
      @(negedge clk);
      in_valid = 1; in_row = 64'h1122334455667788; out_ready = 1;
      #1;
      check("R6 in_ready low while idle", 64'(in_ready), 64'd0);
      @(negedge clk);
      check("R6 no output from idle row", 64'(out_valid), 64'd0);
      in_valid = 0;
      // table walk: R2 R3 R4 R5 R7 R9
      for (int v = 0; v < NV; v++)
         run_block(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], "R2 R3 R5");
      // hand-computed offsets: 8x8 dc 64 -> offset 9, 4x4 dc 64 -> offset 18
      check("R2 R3 hand 8x8", 64'(model_off(3, 64)), 64'd9);
      check("R2 R3 hand 4x4", 64'(model_off(0, 64)), 64'd18);
      run_block(3, 64, 50, 0, "R2 R3 hand8x8");
      run_block(0, 64, 50, 1, "R2 R3 R5 hand4x4");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule